// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column address stream for a single SDRAM read or write burst. It sits in the column path of a memory device model or a device-side datapath. A start pulse captures an 8-bit starting column, a three-bit burst-length code and an ordering bit. From the next enabled clock the block presents one column address per cycle, together with a valid flag and a flag that marks the final address of the burst.

Fixed bursts of 2, 4 or 8 wrap inside an aligned block of columns, in either linear or interleaved order. A full-page burst walks the whole 256-column row and keeps wrapping until it is stopped. A terminate pulse ends a burst early; this covers both the burst-stop and the precharge cases. A new start on any cycle discards the running burst. When the clock enable input is low, the whole block is frozen for that edge.

Top module: `sdram_col_burst_gen`

## Requirements
- R1: After reset, col_valid and col_last are 0 and col_addr is 0.
- R2: A start sampled with cke high makes the next cycle show col_valid=1 and col_addr equal to the captured start_col.
- R3: With ordering bit interleave=0 and length L in {2,4,8}, the k-th address (k from 0) is the start column with its low log2(L) bits replaced by (start low bits + k) mod L. The upper bits do not change.
- R4: With interleave=1 and length L in {2,4,8}, the k-th address is start_col XOR k. Since k < L, only the low log2(L) bits change.
- R5: With len_code 3'b111 (full page), the k-th address is (start_col + k) mod 256. The burst continues past 256 addresses, col_last stays 0, and interleave has no effect.
- R6: col_last is 1 exactly on the final address of a fixed-length burst. In the following cycle col_valid is 0, unless a new start was sampled.
- R7: len_code decodes as 3'b000=1, 3'b001=2, 3'b010=4, 3'b011=8 and 3'b111=full page. The codes 3'b100, 3'b101 and 3'b110 act as length 1.
- R8: A term pulse sampled with cke high and no start makes the next cycle show col_valid=0 and col_last=0.
- R9: A start sampled during a running burst replaces it at once. A start and a term in the same cycle act as a start.
- R10: While cke is low, col_addr, col_valid and col_last keep their values, and start and term are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable; low freezes the block for that edge |
| start | input | 1 | Load a new burst |
| start_col | input | 8 | Starting column of the new burst |
| len_code | input | 3 | Burst length code |
| interleave | input | 1 | 1 selects interleaved order, 0 selects linear order |
| term | input | 1 | End the running burst |
| col_addr | output | 8 | Current column address |
| col_valid | output | 1 | col_addr belongs to a live burst |
| col_last | output | 1 | col_addr is the final address of a fixed burst |

## Verification
A new start can arrive in the same cycle as a terminate pulse. It can also arrive in the cycle that carries the last address of a burst. The bench provokes the first case by raising start and term together in the middle of an 8-beat burst. The expected result is the complete new 4-beat sequence, with nothing of the old burst left over. The frozen clock also meets a start: a start pulse raised while cke is low must leave the paused address in place and must not disturb how the old burst resumes.

// File: rtl/sdram_cb_pkg.sv
package sdram_cb_pkg;

    typedef enum logic [2:0] {
        BL_ONE  = 3'b000,
        BL_TWO  = 3'b001,
        BL_FOUR = 3'b010,
        BL_EIGHT= 3'b011,
        BL_PAGE = 3'b111
    } blen_e;

endpackage

// File: rtl/sdram_cb_len_decode.sv
module sdram_cb_len_decode
    import sdram_cb_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [2:0]       code,
    output logic [COL_W-1:0] wrap_mask,
    output logic             page_mode
);

    // wrap_mask is (length - 1); full page uses every column bit
    always_comb begin
        page_mode = 1'b0;
        unique case (code)
            BL_TWO:   wrap_mask = COL_W'(1);
            BL_FOUR:  wrap_mask = COL_W'(3);
            BL_EIGHT: wrap_mask = COL_W'(7);
            BL_PAGE: begin
                wrap_mask = '1;
                page_mode = 1'b1;
            end
            default:  wrap_mask = '0;
        endcase
    end

endmodule

// File: rtl/sdram_cb_addr_calc.sv
module sdram_cb_addr_calc #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] wrap_mask,
    input  logic [COL_W-1:0] beat,
    input  logic             ilv,
    input  logic             page_mode,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] lin_sum;

    always_comb begin
        lin_sum = base + beat;
        if (ilv && !page_mode) begin
            col = base ^ (beat & wrap_mask);
        end else begin
            col = (base & ~wrap_mask) | (lin_sum & wrap_mask);
        end
    end

endmodule

// File: rtl/sdram_col_burst_gen.sv
module sdram_col_burst_gen #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       len_code,
    input  logic             interleave,
    input  logic             term,
    output logic [COL_W-1:0] col_addr,
    output logic             col_valid,
    output logic             col_last
);

    localparam logic [COL_W-1:0] ONE = COL_W'(1);

    typedef struct packed {
        logic             active;
        logic             page;
        logic             ilv;
        logic             last;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] beat;
        logic [COL_W-1:0] col;
    } burst_t;

    burst_t state_d, state_q;

    logic [COL_W-1:0] dec_mask_d;
    logic             dec_page_d;
    logic [COL_W-1:0] beat_inc_d;
    logic [COL_W-1:0] step_col_d;

    sdram_cb_len_decode #(.COL_W(COL_W)) i_decode (
        .code      (len_code),
        .wrap_mask (dec_mask_d),
        .page_mode (dec_page_d)
    );

    assign beat_inc_d = state_q.beat + ONE;

    sdram_cb_addr_calc #(.COL_W(COL_W)) i_calc (
        .base      (state_q.base),
        .wrap_mask (state_q.mask),
        .beat      (beat_inc_d),
        .ilv       (state_q.ilv),
        .page_mode (state_q.page),
        .col       (step_col_d)
    );

    always_comb begin
        state_d = state_q;
        if (cke) begin
            if (start) begin
                state_d.active = 1'b1;
                state_d.page   = dec_page_d;
                state_d.ilv    = interleave;
                state_d.mask   = dec_mask_d;
                state_d.base   = start_col;
                state_d.beat   = '0;
                state_d.col    = start_col;
                state_d.last   = !dec_page_d && (dec_mask_d == '0);
            end else if (term || (state_q.active && state_q.last)) begin
                state_d.active = 1'b0;
                state_d.last   = 1'b0;
            end else if (state_q.active) begin
                state_d.beat   = beat_inc_d;
                state_d.col    = step_col_d;
                state_d.last   = !state_q.page && (beat_inc_d == state_q.mask);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign col_addr  = state_q.col;
    assign col_valid = state_q.active;
    assign col_last  = state_q.last;

    a_r1_reset_idle: assert property (@(posedge clk)
        $past(!rst_n) |-> (!col_valid && !col_last));

    a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && start) |=> (col_valid && col_addr == $past(start_col)));

    a_r5_page_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && col_valid && state_q.page && !start && !term)
        |=> (col_valid && !col_last && col_addr == $past(col_addr) + ONE));

    a_r6_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid);

    a_r6_after_last_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && col_last && !start) |=> !col_valid);

    a_r8_term_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && term && !start) |=> (!col_valid && !col_last));

    a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> ($stable(col_addr) && $stable(col_valid) && $stable(col_last)));

endmodule

// File: tb/test_sdram_col_burst_gen.sv
module test_sdram_col_burst_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke = 1'b1;
    logic       start = 1'b0;
    logic [7:0] start_col = '0;
    logic [2:0] len_code = '0;
    logic       interleave = 1'b0;
    logic       term = 1'b0;
    logic [7:0] col_addr;
    logic       col_valid;
    logic       col_last;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sdram_col_burst_gen i_sdram_col_burst_gen (
        .clk(clk), .rst_n(rst_n), .cke(cke), .start(start),
        .start_col(start_col), .len_code(len_code), .interleave(interleave),
        .term(term), .col_addr(col_addr), .col_valid(col_valid),
        .col_last(col_last)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_col(int base, int len, bit ilv, bit page, int k);
        if (page) return (base + k) % 256;
        if (ilv) return base ^ k;
        return (base / len) * len + ((base % len) + k) % len;
    endfunction

    // drive a start for one enabled edge; returns at the negedge showing beat 0
    task automatic begin_burst(input int col, input logic [2:0] code, input bit ilv);
        start = 1'b1; start_col = 8'(col); len_code = code; interleave = ilv;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic walk(input string req, input int base, input int len, input bit ilv,
                        input bit page, input int from, input int count);
        for (int k = from; k < from + count; k++) begin
            chk(req, col_addr, exp_col(base, len, ilv, page, k));
            chk(req, col_valid, 1);
            chk(req, col_last, (!page && k == len - 1) ? 1 : 0);
            if (k < from + count - 1) @(negedge clk);
        end
    endtask

    task automatic expect_idle(input string req);
        @(negedge clk);
        chk(req, col_valid, 0);
        chk(req, col_last, 0);
    endtask

    task automatic t_reset;
        chk("R1", col_valid, 0);
        chk("R1", col_last, 0);
        chk("R1", col_addr, 0);
    endtask

    task automatic t_linear;
        begin_burst(8'h3D, 3'b011, 1'b0);
        walk("R3 len8", 8'h3D, 8, 1'b0, 1'b0, 0, 8);
        expect_idle("R6 after len8");
        begin_burst(8'h12, 3'b010, 1'b0);
        walk("R3 len4", 8'h12, 4, 1'b0, 1'b0, 0, 4);
        expect_idle("R6 after len4");
        begin_burst(8'hA7, 3'b001, 1'b0);
        walk("R2 len2", 8'hA7, 2, 1'b0, 1'b0, 0, 2);
        expect_idle("R6 after len2");
    endtask

    task automatic t_interleave;
        begin_burst(8'h3D, 3'b011, 1'b1);
        walk("R4 len8", 8'h3D, 8, 1'b1, 1'b0, 0, 8);
        expect_idle("R6 ilv8");
        begin_burst(8'h81, 3'b001, 1'b1);
        walk("R4 len2", 8'h81, 2, 1'b1, 1'b0, 0, 2);
        expect_idle("R6 ilv2");
        begin_burst(8'hC6, 3'b010, 1'b1);
        walk("R4 len4", 8'hC6, 4, 1'b1, 1'b0, 0, 4);
        expect_idle("R6 ilv4");
    endtask

    task automatic t_single;
        logic [2:0] codes [4] = '{3'b000, 3'b100, 3'b101, 3'b110};
        foreach (codes[i]) begin
            begin_burst(8'h50 + i, codes[i], 1'b0);
            walk("R7 single", 8'h50 + i, 1, 1'b0, 1'b0, 0, 1);
            expect_idle("R7 single end");
        end
    endtask

    task automatic t_page;
        begin_burst(8'hFE, 3'b111, 1'b1);
        walk("R5 page", 8'hFE, 256, 1'b1, 1'b1, 0, 260);
        term = 1'b1;
        @(negedge clk);
        term = 1'b0;
        chk("R8 page term", col_valid, 0);
        chk("R8 page term", col_last, 0);
    endtask

    task automatic t_term;
        begin_burst(8'h40, 3'b011, 1'b0);
        walk("R3 pre-term", 8'h40, 8, 1'b0, 1'b0, 0, 3);
        term = 1'b1;
        @(negedge clk);
        term = 1'b0;
        chk("R8 term", col_valid, 0);
        chk("R8 term", col_last, 0);
        expect_idle("R8 stays idle");
    endtask

    task automatic t_restart;
        begin_burst(8'h10, 3'b011, 1'b0);
        walk("R2 old", 8'h10, 8, 1'b0, 1'b0, 0, 2);
        term = 1'b1;
        begin_burst(8'h55, 3'b010, 1'b0);
        term = 1'b0;
        walk("R9 restart", 8'h55, 4, 1'b0, 1'b0, 0, 4);
        // restart on the last beat extends into a fresh burst
        begin_burst(8'h0E, 3'b001, 1'b1);
        walk("R9 on last", 8'h0E, 2, 1'b1, 1'b0, 0, 2);
        expect_idle("R9 end");
    endtask

    task automatic t_freeze;
        begin_burst(8'h20, 3'b011, 1'b0);
        walk("R3 pre-freeze", 8'h20, 8, 1'b0, 1'b0, 0, 2);
        cke = 1'b0;
        start = 1'b1; start_col = 8'h99; len_code = 3'b000; term = 1'b1;
        for (int n = 0; n < 3; n++) begin
            @(negedge clk);
            start = 1'b0; term = 1'b0;
            chk("R10 hold addr", col_addr, 8'h21);
            chk("R10 hold valid", col_valid, 1);
            chk("R10 hold last", col_last, 0);
        end
        cke = 1'b1;
        @(negedge clk);
        walk("R10 resume", 8'h20, 8, 1'b0, 1'b0, 2, 6);
        expect_idle("R10 end");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        @(negedge clk);
        t_linear();
        t_interleave();
        t_single();
        t_page();
        t_term();
        t_restart();
        t_freeze();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule